// File: doc/BRIEF.md
# Smart-Card Slot Select Controller

This block is the slot-select control register of a contact smart-card interface that serves two card slots. Software reaches it over a simple register bus with address, write enable, write data and combinational read data. The register holds the auxiliary slot select, the auxiliary clock enable, the presence-pin pull direction and the presence connector type. Its bit 0 is an active-low soft-reset request that hardware sets back to 1 by itself.

A soft reset clears the configuration and emits a one-cycle pulse that resets the whole contact interface. If slot 1 is active when the request arrives, the controller first holds a deactivation request to the slot-1 sequencer and waits for it to report completion. Any change of the slot select emits a separate one-cycle pulse. Downstream logic uses that pulse to reset the ISO UART, its error and event flags, the timers and the timeout configuration.

The presence pin is synchronized through two flops and turned into a single "card inserted" signal for both connector types. The auxiliary card clock passes to its output only while enabled.

Top module: `slot_sel_ctrl`

## Requirements
- R1: After reset, a read of the register at address 0 returns 0x00000001, and full_rst_pulse, slot_switch_rst and slot1_deact_req are all 0.
- R2: The bits of the register at address 0 are: bit1 auxiliary slot select, bit2 auxiliary clock enable, bit3 presence pull-up select, bit4 normally-open connector select. A write with bit0 = 1 loads bits 4:1. Bits 31:5 always read 0. A read of any other address returns 0, and a write to any other address has no effect.
- R3: A write of bit0 = 0 while slot1_active is 0 does not load bits 4:1. In the next cycle bit0 reads 0 and full_rst_pulse is 1 for exactly that one cycle. In the cycle after that, bit0 reads 1 and bits 4:1 read 0.
- R4: A write of bit0 = 0 while slot1_active is 1 raises slot1_deact_req from the next cycle, and the request holds until slot1_deact_done is sampled high. In the cycle after that sample, slot1_deact_req is 0 and full_rst_pulse is 1. In the cycle after the pulse, bit0 reads 1 again. Bit0 reads 0 throughout the wait.
- R5: Writes to the register are ignored while a soft reset is in progress, so bits 4:1 keep their value.
- R6: slot_switch_rst is 1 for exactly the one cycle that follows any clock edge at which bit1 changes value, including a change caused by a soft reset. It is 0 in every other cycle.
- R7: aux_clk_out equals aux_clk_in while bit2 is 1 and is held at 0 while bit2 is 0.
- R8: pres_pull_up equals bit3 (1 selects pull-up, 0 selects pull-down).
- R9: card_present equals the presence pin after two-flop synchronization, XORed with bit4. A pin change reaches card_present after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| slot1_active | input | 1 | Slot 1 is currently activated |
| slot1_deact_done | input | 1 | Slot-1 deactivation finished |
| slot1_deact_req | output | 1 | Request automatic deactivation of slot 1 |
| full_rst_pulse | output | 1 | One-cycle reset of the whole contact interface |
| slot_switch_rst | output | 1 | One-cycle reset of UART, flags, timers and timeout config |
| aux_slot_sel | output | 1 | Auxiliary slot selected |
| aux_clk_in | input | 1 | Auxiliary card clock source |
| aux_clk_out | output | 1 | Gated auxiliary card clock |
| pres_pin | input | 1 | Asynchronous presence-pin level |
| pres_pull_up | output | 1 | Presence pull-up (1) or pull-down (0) select |
| card_present | output | 1 | Card inserted, for either connector type |

## Verification
The embedded assertions check on every cycle that the soft-reset pulse is never longer than one cycle and leaves bits 4:1 cleared. They also check that the deactivation request holds until completion and falls exactly when the pulse rises, that the slot-switch pulse appears only after a real change of the select, and that writes during the deactivation wait leave the configuration alone. The bench scenarios show what the properties cannot: the exact read values seen while polling, that writes to bit0 = 0 and to foreign addresses have no effect, the reserved bits, the clock gating, and the two-cycle latency and polarity of the presence path.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

  localparam int CFG_W = 4;

  // Field order matches bus bits 4:1, msb first.
  typedef struct packed {
    logic con_no;
    logic pull_up;
    logic clk_aux_en;
    logic aux_sel;
  } cfg_t;

  typedef enum logic [1:0] {
    SR_IDLE    = 2'd0,
    SR_WAIT    = 2'd1,
    SR_RELEASE = 2'd2
  } sr_state_e;

endpackage

// File: rtl/pres_sync.sv
module pres_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = din;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/soft_rst_fsm.sv
module soft_rst_fsm
  import slot_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slot1_active,
  input  logic deact_done,
  output logic busy,
  output logic deact_req,
  output logic rst_pulse
);

  sr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SR_IDLE:    if (start) state_d = slot1_active ? SR_WAIT : SR_RELEASE;
      SR_WAIT:    if (deact_done) state_d = SR_RELEASE;
      SR_RELEASE: state_d = SR_IDLE;
      default:    state_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SR_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != SR_IDLE);
  assign deact_req = (state_q == SR_WAIT);
  assign rst_pulse = (state_q == SR_RELEASE);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R4
  deact_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_req && !deact_done) |=> deact_req);

  // R4
  deact_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(deact_req) |-> rst_pulse);

endmodule

// File: rtl/slot_sel_ctrl.sv
module slot_sel_ctrl
  import slot_sel_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  REG_ADDR   = 8'h00,
  parameter int          SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slot1_active,
  input  logic              slot1_deact_done,
  output logic              slot1_deact_req,
  output logic              full_rst_pulse,
  output logic              slot_switch_rst,
  output logic              aux_slot_sel,
  input  logic              aux_clk_in,
  output logic              aux_clk_out,
  input  logic              pres_pin,
  output logic              pres_pull_up,
  output logic              card_present
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  cfg_t cfg_q, cfg_d;
  logic sw_q, sw_d;
  logic busy;
  logic wr_hit;
  logic sr_start;
  logic pres_s;

  assign wr_hit   = bus_we && (bus_addr == MY_ADDR);
  assign sr_start = wr_hit && !busy && !bus_wdata[0];

  soft_rst_fsm u_sr (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (sr_start),
    .slot1_active (slot1_active),
    .deact_done   (slot1_deact_done),
    .busy         (busy),
    .deact_req    (slot1_deact_req),
    .rst_pulse    (full_rst_pulse)
  );

  pres_sync #(.STAGES(SYNC_STAGE)) u_pres (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pres_pin),
    .dout  (pres_s)
  );

  // Next-state for configuration and slot-switch pulse
  always_comb begin
    cfg_d = cfg_q;
    if (full_rst_pulse)
      cfg_d = '0;
    else if (wr_hit && !busy && bus_wdata[0])
      cfg_d = cfg_t'(bus_wdata[CFG_W:1]);
    sw_d = (cfg_d.aux_sel != cfg_q.aux_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      sw_q  <= sw_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MY_ADDR)
      bus_rdata[CFG_W:0] = {cfg_q, ~busy};
  end

  assign slot_switch_rst = sw_q;
  assign aux_slot_sel    = cfg_q.aux_sel;
  assign aux_clk_out     = aux_clk_in & cfg_q.clk_aux_en;
  assign pres_pull_up    = cfg_q.pull_up;
  assign card_present    = pres_s ^ cfg_q.con_no;

  // R5
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot1_deact_req && bus_we) |=> $stable(cfg_q));

  // R3
  cfg_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_pulse |=> (cfg_q == '0));

  // R6
  switch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_switch_rst |-> (cfg_q.aux_sel != $past(cfg_q.aux_sel)));

endmodule

// File: tb/slot_sel_ctrl_tb_top.sv
module slot_sel_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        slot1_active, slot1_deact_done, slot1_deact_req;
  logic        full_rst_pulse, slot_switch_rst, aux_slot_sel;
  logic        aux_clk_in, aux_clk_out, pres_pin, pres_pull_up, card_present;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  slot_sel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slot1_active(slot1_active), .slot1_deact_done(slot1_deact_done),
    .slot1_deact_req(slot1_deact_req), .full_rst_pulse(full_rst_pulse),
    .slot_switch_rst(slot_switch_rst), .aux_slot_sel(aux_slot_sel),
    .aux_clk_in(aux_clk_in), .aux_clk_out(aux_clk_out),
    .pres_pin(pres_pin), .pres_pull_up(pres_pull_up),
    .card_present(card_present)
  );

  // {write data bits 4:0, expected read bits 4:0, expected slot_switch_rst}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {5'h1F, 5'h1F, 1'b1},
    {5'h1D, 5'h1D, 1'b1},
    {5'h19, 5'h19, 1'b0},
    {5'h03, 5'h03, 1'b1},
    {5'h13, 5'h13, 1'b0},
    {5'h01, 5'h01, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a write at the falling edge, then step to the next falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    slot1_active = 1'b0; slot1_deact_done = 1'b0;
    aux_clk_in = 1'b0; pres_pin = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h1);
    check("R1 pulses", {31'b0, full_rst_pulse | slot_switch_rst | slot1_deact_req}, 32'h0);

    // R2 / R6 table walk
    for (int i = 0; i < NV; i++) begin
      wr(8'h00, {27'h7FFFFFF, VEC[i][10:6]});
      check("R2 readback", bus_rdata, {27'b0, VEC[i][5:1]});
      check("R6 switch pulse", {31'b0, slot_switch_rst}, {31'b0, VEC[i][0]});
    end
    step(1);
    check("R6 pulse one cycle", {31'b0, slot_switch_rst}, 32'h0);

    // R2 foreign address: write ignored, read zero
    wr(8'h04, 32'h0);
    check("R2 foreign no soft reset", {31'b0, full_rst_pulse}, 32'h0);
    bus_addr = 8'h04; #1;
    check("R2 foreign read", bus_rdata, 32'h0);
    bus_addr = 8'h00; #1;
    check("R2 own unchanged", bus_rdata, 32'h1);

    // R7 / R8
    aux_clk_in = 1'b1; #1;
    check("R7 clk stopped", {31'b0, aux_clk_out}, 32'h0);
    wr(8'h00, 32'h0F);
    check("R7 clk passed", {31'b0, aux_clk_out}, 32'h1);
    check("R8 pull-up", {31'b0, pres_pull_up}, 32'h1);
    aux_clk_in = 1'b0; #1;
    check("R7 clk follows", {31'b0, aux_clk_out}, 32'h0);

    // R3 soft reset, slot 1 idle; bits 4:1 of the write must not load
    wr(8'h00, 32'h1E);
    check("R3 bit0 low", bus_rdata, 32'h0E);
    check("R3 pulse high", {31'b0, full_rst_pulse}, 32'h1);
    step(1);
    check("R3 restored", bus_rdata, 32'h1);
    check("R3 pulse one cycle", {31'b0, full_rst_pulse}, 32'h0);
    check("R6 pulse from soft reset", {31'b0, slot_switch_rst}, 32'h1);
    check("R8 pull-down after reset", {31'b0, pres_pull_up}, 32'h0);

    // R4 / R5 soft reset with slot 1 active
    wr(8'h00, 32'h03);
    slot1_active = 1'b1;
    wr(8'h00, 32'h00);
    check("R4 deact req", {31'b0, slot1_deact_req}, 32'h1);
    check("R4 bit0 low while waiting", bus_rdata, 32'h02);
    step(3);
    check("R4 req held", {31'b0, slot1_deact_req}, 32'h1);
    check("R4 no pulse yet", {31'b0, full_rst_pulse}, 32'h0);
    wr(8'h00, 32'h1F);
    check("R5 write ignored", bus_rdata, 32'h02);
    slot1_deact_done = 1'b1;
    step(1);
    slot1_deact_done = 1'b0; slot1_active = 1'b0;
    check("R4 pulse after done", {31'b0, full_rst_pulse}, 32'h1);
    check("R4 req dropped", {31'b0, slot1_deact_req}, 32'h0);
    step(1);
    check("R4 restored", bus_rdata, 32'h1);

    // R9 presence path, normally-closed type
    pres_pin = 1'b1;
    step(1);
    check("R9 not after one edge", {31'b0, card_present}, 32'h0);
    step(1);
    check("R9 after two edges", {31'b0, card_present}, 32'h1);
    wr(8'h00, 32'h11);
    check("R9 normally-open inverts", {31'b0, card_present}, 32'h0);
    pres_pin = 1'b0;
    step(2);
    check("R9 normally-open low pin", {31'b0, card_present}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule